// File: doc/BRIEF.md
# Page Permission Fault Checker

This block decides whether a memory access that has already been translated may proceed. It takes the effective permission bits of the final page (user-accessible, writable, no-execute), plus the directory-level user and writable bits when the page was reached through a two-level walk that ends in a small page. It also takes the kind of access and the privilege context the access runs under. From these it produces a fault flag and the error code a page-fault handler would receive.

Three privilege contexts are supported. The first is user. The second is plain kernel. The third is kernel with the access-prevention override, which a supervisor uses while it deliberately touches user memory. Each context applies its own rule set. The supervisor rules add execution prevention (no fetching from user pages) and access prevention (no data access to user pages) on top of the classic write-protect check.

A request is presented with `req_valid` in any cycle, with no backpressure. The verdict is registered and shows up on the response port in the next cycle.

Top module: `pgperm_check`

## Requirements
- R1: `rsp_valid` equals `req_valid` of the previous cycle. While `rsp_valid` is 0, `rsp_fault` and `rsp_err` are 0. All outputs are 0 after reset.
- R2: An instruction fetch (`acc_type` = 2) to a page with `leaf_nx` = 1 faults, whatever the privilege context.
- R3: In user context (`mode_idx` = 1), an access faults if the effective user bit is 0. A write (`acc_type` = 1) also faults if the effective writable bit is 0.
- R4: In plain kernel context (`mode_idx` = 0, or the otherwise unused value 3), a read or write to a page whose effective user bit is 1 faults when `aprev_en` = 1. It does not fault for this reason when `aprev_en` = 0.
- R5: In both supervisor contexts (`mode_idx` 0, 2 or 3), a fetch from a page whose effective user bit is 1 faults when `xprev_en` = 1. `aprev_en` has no effect on fetches.
- R6: In both supervisor contexts, a write to a page whose effective writable bit is 0 faults only when `wp_en` = 1.
- R7: In the override context (`mode_idx` = 2), data reads and writes to user pages never fault because of `aprev_en`. All other supervisor checks still apply.
- R8: When a fault is reported, `rsp_err` is formed as follows:
  - bit 0 is 1;
  - bit 1 is 1 for a write;
  - bit 2 is 1 in user context;
  - bit 3 is 0;
  - bit 4 is 1 for a fetch when either (`nxe_en` and `pae_en` are both 1) or `xprev_en` is 1.
  
  Without a fault, `rsp_err` is 0.
- R9: With `two_level` = 1, the effective user and writable bits are the AND of the directory bits and the leaf bits. With `two_level` = 0, `dir_user` and `dir_rw` are ignored. `acc_type` = 3 is treated as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| acc_type | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| mode_idx | input | 2 | 0 kernel, 1 user, 2 kernel with override, 3 kernel |
| leaf_user | input | 1 | Leaf entry user bit |
| leaf_rw | input | 1 | Leaf entry writable bit |
| leaf_nx | input | 1 | Effective no-execute bit of the page |
| dir_user | input | 1 | Directory entry user bit |
| dir_rw | input | 1 | Directory entry writable bit |
| two_level | input | 1 | Small page reached through a two-level walk |
| wp_en | input | 1 | Supervisor write-protect enable |
| xprev_en | input | 1 | Supervisor execution prevention enable |
| aprev_en | input | 1 | Supervisor access prevention enable |
| pae_en | input | 1 | Physical address extension enabled |
| nxe_en | input | 1 | No-execute enable |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Access must fault |
| rsp_err | output | 5 | Page-fault error code |

## Verification
The assertions assume the inputs carry a fixed meaning. `leaf_nx` is taken to be the already-qualified no-execute bit: masking it with the no-execute enable is left to the caller. The properties that look at leaf bits alone also require `two_level` = 0, so that the directory bits cannot change the verdict.

The stimulus holds every request stable from one falling edge to the next. It sweeps every combination of access type, context and control bit with `two_level` low. Directed cases cover the directory merge and the idle cycles.

// File: rtl/pgperm_check.sv
module pgperm_check #(
  parameter int ERR_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       acc_type,
  input  logic [1:0]       mode_idx,
  input  logic             leaf_user,
  input  logic             leaf_rw,
  input  logic             leaf_nx,
  input  logic             dir_user,
  input  logic             dir_rw,
  input  logic             two_level,
  input  logic             wp_en,
  input  logic             xprev_en,
  input  logic             aprev_en,
  input  logic             pae_en,
  input  logic             nxe_en,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [ERR_W-1:0] rsp_err
);
  localparam logic [1:0] ACC_WRITE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;
  localparam logic [1:0] MODE_USER = 2'd1;
  localparam logic [1:0] MODE_OVR  = 2'd2;

  logic eff_user, eff_rw, is_write, is_fetch, in_user, in_ovr, in_krn;
  logic f_nx, f_user, f_aprev, f_xprev, f_wp, fault, ifetch_bit;
  logic [ERR_W-1:0] err;

  assign eff_user = two_level ? (leaf_user & dir_user) : leaf_user;
  assign eff_rw   = two_level ? (leaf_rw & dir_rw) : leaf_rw;
  assign is_write = (acc_type == ACC_WRITE);
  assign is_fetch = (acc_type == ACC_FETCH);
  assign in_user  = (mode_idx == MODE_USER);
  assign in_ovr   = (mode_idx == MODE_OVR);
  assign in_krn   = !in_user && !in_ovr;

  assign f_nx    = is_fetch & leaf_nx;
  assign f_user  = in_user & (!eff_user | (is_write & !eff_rw));
  assign f_aprev = in_krn & !is_fetch & aprev_en & eff_user;
  assign f_xprev = !in_user & is_fetch & xprev_en & eff_user;
  assign f_wp    = !in_user & wp_en & is_write & !eff_rw;
  assign fault   = f_nx | f_user | f_aprev | f_xprev | f_wp;

  assign ifetch_bit = is_fetch & ((nxe_en & pae_en) | xprev_en);

  always_comb begin
    err = '0;
    if (fault) begin
      err[0] = 1'b1;
      err[1] = is_write;
      err[2] = in_user;
      err[4] = ifetch_bit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_err   <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid & fault;
      rsp_err   <= req_valid ? err : '0;
    end
  end
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva #(
  parameter int ERR_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [1:0]       acc_type,
  input logic [1:0]       mode_idx,
  input logic             leaf_user,
  input logic             leaf_rw,
  input logic             leaf_nx,
  input logic             two_level,
  input logic             wp_en,
  input logic             aprev_en,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [ERR_W-1:0] rsp_err
);
  assert_rsp_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_fault && rsp_err == '0));
  assert_nx_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && acc_type == 2'd2 && leaf_nx) |=> rsp_fault);
  assert_user_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_idx == 2'd1 && !two_level && !leaf_user) |=> rsp_fault);
  assert_aprev_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_idx == 2'd0 && acc_type == 2'd0 && aprev_en
     && !two_level && leaf_user) |=> rsp_fault);
  assert_wp_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_idx == 2'd0 && acc_type == 2'd1 && !wp_en
     && !leaf_user && !leaf_rw && !two_level) |=> !rsp_fault);
  assert_override_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mode_idx == 2'd2 && acc_type == 2'd0 && !two_level
     && leaf_user) |=> !rsp_fault);
  assert_err_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_err[0] && !rsp_err[3]));
  assert_err_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_err == '0));
endmodule

bind pgperm_check pgperm_check_sva #(.ERR_W(ERR_W)) sva_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
  .mode_idx(mode_idx), .leaf_user(leaf_user), .leaf_rw(leaf_rw),
  .leaf_nx(leaf_nx), .two_level(two_level), .wp_en(wp_en),
  .aprev_en(aprev_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
  .rsp_err(rsp_err)
);

// File: tb/pgperm_check_tb_top.sv
`timescale 1ns/1ps
module pgperm_check_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] acc_type = '0, mode_idx = '0;
  logic leaf_user = 0, leaf_rw = 0, leaf_nx = 0, dir_user = 0, dir_rw = 0;
  logic two_level = 0, wp_en = 0, xprev_en = 0, aprev_en = 0, pae_en = 0, nxe_en = 0;
  logic rsp_valid, rsp_fault;
  logic [4:0] rsp_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pgperm_check dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_type(acc_type),
    .mode_idx(mode_idx), .leaf_user(leaf_user), .leaf_rw(leaf_rw),
    .leaf_nx(leaf_nx), .dir_user(dir_user), .dir_rw(dir_rw),
    .two_level(two_level), .wp_en(wp_en), .xprev_en(xprev_en),
    .aprev_en(aprev_en), .pae_en(pae_en), .nxe_en(nxe_en),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_err(rsp_err)
  );

  function automatic logic [5:0] model(input logic [1:0] a, input logic [1:0] m,
      input logic lu, lr, lnx, du, drw, tl, wp, xp, ap, pae, nxe);
    logic u, w, fetch, wr, f;
    logic [4:0] e;
    u = tl ? (lu && du) : lu;
    w = tl ? (lr && drw) : lr;
    fetch = (a == 2);
    wr = (a == 1);
    f = 0;
    if (fetch && lnx) f = 1;
    case (m)
      2'd1: if (!u || (wr && !w)) f = 1;
      2'd2: begin
        if (fetch && xp && u) f = 1;
        if (wr && wp && !w) f = 1;
      end
      default: begin
        if (!fetch && ap && u) f = 1;
        if (fetch && xp && u) f = 1;
        if (wr && wp && !w) f = 1;
      end
    endcase
    e = 5'd0;
    if (f) e = {fetch && ((nxe && pae) || xp), 1'b0, m == 2'd1, wr, 1'b1};
    return {f, e};
  endfunction

  task automatic check(input string tag, input logic ev, input logic ef,
                       input logic [4:0] ee);
    checks++;
    if (rsp_valid !== ev || rsp_fault !== ef || rsp_err !== ee) begin
      errors++;
      $display("FAIL %s: got v=%b f=%b e=%b, expected v=%b f=%b e=%b",
               tag, rsp_valid, rsp_fault, rsp_err, ev, ef, ee);
    end
  endtask

  task automatic run(input string tag, input logic [1:0] a, input logic [1:0] m,
      input logic lu, lr, lnx, du, drw, tl, wp, xp, ap, pae, nxe,
      input logic ef, input logic [4:0] ee);
    @(negedge clk);
    req_valid = 1; acc_type = a; mode_idx = m;
    leaf_user = lu; leaf_rw = lr; leaf_nx = lnx; dir_user = du; dir_rw = drw;
    two_level = tl; wp_en = wp; xprev_en = xp; aprev_en = ap;
    pae_en = pae; nxe_en = nxe;
    @(negedge clk);
    check(tag, 1'b1, ef, ee);
  endtask

  task automatic t_reset_idle();
    check("R1 reset", 1'b0, 1'b0, 5'd0);
    @(negedge clk);
    req_valid = 0; acc_type = 2; leaf_nx = 1; mode_idx = 1;
    @(negedge clk);
    check("R1 idle", 1'b0, 1'b0, 5'd0);
  endtask

  task automatic t_nx();
    run("R2 kernel nx", 2, 0, 0,1,1, 0,0,0, 0,0,0, 0,0, 1, 5'b00001);
    run("R2 user nx",   2, 1, 1,1,1, 0,0,0, 0,0,0, 1,1, 1, 5'b10101);
    run("R2 ovr nx",    2, 2, 0,1,1, 0,0,0, 0,0,0, 1,1, 1, 5'b10001);
  endtask

  task automatic t_user();
    run("R3 no user bit", 0, 1, 0,1,0, 0,0,0, 0,0,0, 0,0, 1, 5'b00101);
    run("R3 write ro",    1, 1, 1,0,0, 0,0,0, 0,0,0, 0,0, 1, 5'b00111);
    run("R3 write rw",    1, 1, 1,1,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
  endtask

  task automatic t_aprev();
    run("R4 read user pg", 0, 0, 1,1,0, 0,0,0, 0,0,1, 0,0, 1, 5'b00001);
    run("R4 aprev off",    0, 0, 1,1,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
    run("R4 mode3 write",  1, 3, 1,1,0, 0,0,0, 0,0,1, 0,0, 1, 5'b00011);
  endtask

  task automatic t_xprev();
    run("R5 ovr fetch",     2, 2, 1,1,0, 0,0,0, 0,1,0, 0,0, 1, 5'b10001);
    run("R5 xprev off",     2, 2, 1,1,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
    run("R5 aprev no fetch",2, 0, 1,1,0, 0,0,0, 0,0,1, 0,0, 0, 5'b00000);
  endtask

  task automatic t_wp();
    run("R6 wp off", 1, 0, 0,0,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
    run("R6 wp on",  1, 0, 0,0,0, 0,0,0, 1,0,0, 0,0, 1, 5'b00011);
    run("R6 ovr wp", 1, 2, 0,0,0, 0,0,0, 1,0,0, 0,0, 1, 5'b00011);
  endtask

  task automatic t_override();
    run("R7 ovr read",  0, 2, 1,1,0, 0,0,0, 0,0,1, 0,0, 0, 5'b00000);
    run("R7 ovr write", 1, 2, 1,1,0, 0,0,0, 1,0,1, 0,0, 0, 5'b00000);
  endtask

  task automatic t_merge();
    run("R9 dir user 0",    0, 1, 1,1,0, 0,1,1, 0,0,0, 0,0, 1, 5'b00101);
    run("R9 dir ignored",   0, 1, 1,1,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
    run("R9 dir rw 0",      1, 1, 1,1,0, 1,0,1, 0,0,0, 0,0, 1, 5'b00111);
    run("R9 acc3 is read",  3, 1, 1,0,0, 0,0,0, 0,0,0, 0,0, 0, 5'b00000);
    run("R9 dir clears apr",0, 0, 1,1,0, 0,1,1, 0,0,1, 0,0, 0, 5'b00000);
  endtask

  task automatic t_sweep();
    for (int i = 0; i < 4096; i++) begin
      logic [11:0] v;
      logic [5:0] x;
      v = i[11:0];
      x = model(v[1:0], v[3:2], v[4], v[5], v[6], 1'b0, 1'b0, 1'b0,
                v[7], v[8], v[9], v[10], v[11]);
      run("R8 sweep", v[1:0], v[3:2], v[4], v[5], v[6], 0, 0, 0,
          v[7], v[8], v[9], v[10], v[11], x[5], x[4:0]);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_idle();
    rst_n = 1;
    t_reset_idle();
    t_nx();
    t_user();
    t_aprev();
    t_xprev();
    t_wp();
    t_override();
    t_merge();
    t_sweep();
    @(negedge clk);
    req_valid = 0;
    @(negedge clk);
    check("R1 drain", 1'b0, 1'b0, 5'd0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule